// File: doc/BRIEF.md
# Multiplexed DRAM Address Permutation Encoder

This block takes a full memory address and presents it to a DRAM whose address pins are time-shared between a row phase and a column phase. Before the split, the address passes through a fixed one-to-one remapping. The remapping walks an Eulerian cycle of the directed graph whose vertices are the half-word values and whose edge (u,v) is the address with upper half u and lower half v. Under this remapping, the column half of one sequential address equals the row half of the next. A sequential sweep therefore toggles the shared pins only inside each address and never between two addresses.

A two-phase sequencer accepts one address per request. It drives the row half with a row strobe in the next cycle and the column half with a column strobe in the cycle after that. A request can be accepted in the column cycle, so back-to-back traffic moves one address every two cycles. An optional invert stage adds one wire and flips a half-word whenever more than half of its bits would otherwise toggle. The memory side recovers the stored address by undoing the invert and applying the inverse mapping. A system can also keep the permuted address as its storage order. A parameter selects plain binary order instead of the permutation, so the two can be compared.

Top module: `pae_dram_addr_enc`

## Requirements
- R1: While reset is held and right after it is released, both strobes are low, ready is high, the bus reads zero and the invert wire is low.
- R2: An address accepted at a clock edge (valid and ready both high) has its row half on the bus with the row strobe high in the next cycle. Its column half follows with the column strobe high in the cycle after that. The two strobes are never high together.
- R3: Ready is low during the row cycle, and a request presented then is ignored. The column half driven next comes from the address that was accepted, and without a new request the block goes idle.
- R4: A request accepted during a column cycle is driven as a row in the very next cycle, with no idle cycle between the two addresses.
- R5: When neither strobe is high and nothing is accepted, the bus and the invert wire keep their values.
- R6: With the permutation selected, let N = 2^HALF_W and let s be the symbol string built for a = 0..N-1 as: a, then for each b > a the pair a, b. Address k then maps to row s[k] and column s[(k+1) mod N^2]. For HALF_W = 2 the codes for addresses 0..15, written {row,col} as a hex nibble, are 0,1,4,2,8,3,D,5,6,9,7,E,A,B,F,C.
- R7: The mapping is a bijection: every {row,col} code belongs to exactly one address.
- R8: In a sequential sweep 0..N^2-1 from reset, the permuted order produces fewer pin transitions than binary order: for HALF_W = 2, 16 against 30.
- R9: With binary order selected, the row half is the upper half of the address and the column half is the lower half.
- R10: With inversion enabled, a half-word whose bits would differ from the current bus in more than HALF_W/2 positions is driven inverted with the invert wire high. Otherwise it is driven unchanged with the invert wire low. Each half is decided against the bus value that precedes it.
- R11: With inversion disabled, the invert wire stays low.
- R12: XOR of the bus with the invert wire, followed by the inverse mapping, returns the original address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address request present |
| req_addr | input | 2*HALF_W | Logical address |
| req_ready | output | 1 | Request can be accepted this cycle |
| bus_addr | output | HALF_W | Shared row/column address pins |
| bus_inv | output | 1 | Invert wire for the current bus value |
| row_strobe | output | 1 | Bus carries a row half |
| col_strobe | output | 1 | Bus carries a column half |

## Verification
In back-to-back traffic, acceptance of a new address falls in the same cycle as the column phase of the one before. In that edge the bus register loads the new row half while the held column half is being driven. The invert decision is then taken against a value that changed only one cycle earlier. The sweep keeps the request valid through every column cycle to provoke this overlap. Each row that follows is checked against the table and against an invert model fed by the preceding column value. The transition totals of the permuted and binary variants are compared at the end of the sweep.

// File: rtl/pae_pkg.sv
package pae_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ROW  = 2'd1,
      PH_COL  = 2'd2
   } pae_phase_e;

   // Symbol at position idx of the cyclic walk over nsym vertices:
   // for each a, emit a, then the pair (a,b) for every b greater than a.
   function automatic int unsigned sym_at(input int unsigned idx, input int unsigned nsym);
      int unsigned pos;
      int unsigned res;
      pos = 0;
      res = 0;
      for (int unsigned a = 0; a < nsym; a++) begin
         if (pos == idx) res = a;
         pos++;
         for (int unsigned b = a + 1; b < nsym; b++) begin
            if (pos == idx) res = a;
            pos++;
            if (pos == idx) res = b;
            pos++;
         end
      end
      return res;
   endfunction

   // Edge k of the cycle: {row, col} = {s[k], s[k+1]}
   function automatic int unsigned perm_code(input int unsigned k, input int unsigned nsym);
      int unsigned nxt;
      nxt = (k + 1) % (nsym * nsym);
      return sym_at(k, nsym) * nsym + sym_at(nxt, nsym);
   endfunction

endpackage

// File: rtl/pae_perm_map.sv
module pae_perm_map #(
   parameter int HALF_W   = 2,
   parameter int MAP_PERM = 1
) (
   input  logic [2*HALF_W-1:0] addr,
   output logic [HALF_W-1:0]   row_half,
   output logic [HALF_W-1:0]   col_half
);
   localparam int AW    = 2 * HALF_W;
   localparam int NSYM  = 1 << HALF_W;
   localparam int NCODE = NSYM * NSYM;

   logic [AW-1:0] tbl [NCODE];
   logic [AW-1:0] code;

   if (MAP_PERM != 0) begin : g_perm
      for (genvar k = 0; k < NCODE; k++) begin : g_ent
         assign tbl[k] = AW'(pae_pkg::perm_code(k, NSYM));
      end
   end else begin : g_bin
      for (genvar k = 0; k < NCODE; k++) begin : g_ent
         assign tbl[k] = AW'(k);
      end
   end

   assign code     = tbl[addr];
   assign row_half = code[AW-1:HALF_W];
   assign col_half = code[HALF_W-1:0];

endmodule

// File: rtl/pae_perm_unmap.sv
module pae_perm_unmap #(
   parameter int HALF_W   = 2,
   parameter int MAP_PERM = 1
) (
   input  logic [HALF_W-1:0]   row_half,
   input  logic [HALF_W-1:0]   col_half,
   output logic [2*HALF_W-1:0] addr
);
   localparam int AW    = 2 * HALF_W;
   localparam int NSYM  = 1 << HALF_W;
   localparam int NCODE = NSYM * NSYM;

   logic [AW-1:0] tbl [NCODE];

   if (MAP_PERM != 0) begin : g_perm
      for (genvar k = 0; k < NCODE; k++) begin : g_ent
         assign tbl[k] = AW'(pae_pkg::perm_code(k, NSYM));
      end
   end else begin : g_bin
      for (genvar k = 0; k < NCODE; k++) begin : g_ent
         assign tbl[k] = AW'(k);
      end
   end

   always_comb begin
      addr = '0;
      for (int k = 0; k < NCODE; k++) begin
         if (tbl[k] == {row_half, col_half}) addr = AW'(k);
      end
   end

endmodule

// File: rtl/pae_phase_seq.sv
module pae_phase_seq #(
   parameter int HALF_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [HALF_W-1:0] col_in,
   output logic              req_ready,
   output logic              take,
   output logic              row_phase,
   output logic              col_phase,
   output logic [HALF_W-1:0] col_held
);
   import pae_pkg::*;

   pae_phase_e state_q, state_d;

   assign req_ready = (state_q != PH_ROW);
   assign take      = req_valid && req_ready;
   assign row_phase = (state_q == PH_ROW);
   assign col_phase = (state_q == PH_COL);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PH_IDLE: state_d = take ? PH_ROW : PH_IDLE;
         PH_ROW:  state_d = PH_COL;
         PH_COL:  state_d = take ? PH_ROW : PH_IDLE;
         default: state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= PH_IDLE;
         col_held <= '0;
      end else begin
         state_q <= state_d;
         if (take) col_held <= col_in;
      end
   end

   a_r2_col_after_row: assert property (@(posedge clk) disable iff (!rst_n)
      row_phase |=> col_phase);
   a_r3_row_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      row_phase |-> !req_ready);
   a_r3_col_kept: assert property (@(posedge clk) disable iff (!rst_n)
      row_phase |=> $stable(col_held));
   a_r4_take_to_row: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> row_phase);

endmodule

// File: rtl/pae_bus_drive.sv
module pae_bus_drive #(
   parameter int HALF_W = 2,
   parameter int INV_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [HALF_W-1:0] raw,
   output logic [HALF_W-1:0] bus_q,
   output logic              inv_q
);

   if (INV_EN != 0) begin : g_inv
      int   tcnt;
      logic flip;
      logic [HALF_W-1:0] nxt;

      always_comb begin
         tcnt = $countones(raw ^ bus_q);
         flip = (2 * tcnt > HALF_W);
         nxt  = flip ? ~raw : raw;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bus_q <= '0;
            inv_q <= 1'b0;
         end else if (load) begin
            bus_q <= nxt;
            inv_q <= flip;
         end
      end

      a_r10_inv_bound: assert property (@(posedge clk) disable iff (!rst_n)
         load |=> ($countones(bus_q ^ $past(bus_q)) <= HALF_W / 2));
      a_r12_inv_restore: assert property (@(posedge clk) disable iff (!rst_n)
         load |=> ((bus_q ^ {HALF_W{inv_q}}) == $past(raw)));
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (!rst_n)    bus_q <= '0;
         else if (load) bus_q <= raw;
      end
      assign inv_q = 1'b0;

      a_r9_plain_load: assert property (@(posedge clk) disable iff (!rst_n)
         load |=> (bus_q == $past(raw)));
   end

endmodule

// File: rtl/pae_dram_addr_enc.sv
module pae_dram_addr_enc #(
   parameter int HALF_W   = 2,
   parameter int MAP_PERM = 1,
   parameter int INV_EN   = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [2*HALF_W-1:0] req_addr,
   output logic                req_ready,
   output logic [HALF_W-1:0]   bus_addr,
   output logic                bus_inv,
   output logic                row_strobe,
   output logic                col_strobe
);
   localparam int AW = 2 * HALF_W;

   if (HALF_W < 1 || HALF_W > 5) begin : g_bad_width
      $error("pae_dram_addr_enc: HALF_W must lie in 1..5");
   end
   if (MAP_PERM < 0 || MAP_PERM > 1) begin : g_bad_map
      $error("pae_dram_addr_enc: MAP_PERM must be 0 or 1");
   end
   if (INV_EN < 0 || INV_EN > 1) begin : g_bad_inv
      $error("pae_dram_addr_enc: INV_EN must be 0 or 1");
   end

   logic [HALF_W-1:0] row_half, col_half, col_held, raw;
   logic              take, row_phase, col_phase, load;
   logic [AW-1:0]     back_addr;

   pae_perm_map #(.HALF_W(HALF_W), .MAP_PERM(MAP_PERM)) u_map (
      .addr     (req_addr),
      .row_half (row_half),
      .col_half (col_half)
   );

   pae_phase_seq #(.HALF_W(HALF_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .col_in    (col_half),
      .req_ready (req_ready),
      .take      (take),
      .row_phase (row_phase),
      .col_phase (col_phase),
      .col_held  (col_held)
   );

   // The row half loads at acceptance; the held column half loads on leaving the row cycle.
   assign load = take || row_phase;
   assign raw  = take ? row_half : col_held;

   pae_bus_drive #(.HALF_W(HALF_W), .INV_EN(INV_EN)) u_drv (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .raw   (raw),
      .bus_q (bus_addr),
      .inv_q (bus_inv)
   );

   assign row_strobe = row_phase;
   assign col_strobe = col_phase;

   pae_perm_unmap #(.HALF_W(HALF_W), .MAP_PERM(MAP_PERM)) u_unmap (
      .row_half (row_half),
      .col_half (col_half),
      .addr     (back_addr)
   );

   a_r12_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (back_addr == req_addr));
   a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(row_strobe && col_strobe));
   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!row_strobe && !col_strobe && !(req_valid && req_ready)) |=>
         ($stable(bus_addr) && $stable(bus_inv)));

endmodule

// File: tb/pae_dram_addr_enc_tb.sv
module pae_dram_addr_enc_tb_top;
   localparam int CLK_P = 10;
   localparam int HW    = 2;
   localparam int AW    = 2 * HW;

   // {address, expected {row,col} code} for the permuted order
   localparam logic [7:0] VEC [16] = '{
      8'h00, 8'h11, 8'h24, 8'h32, 8'h48, 8'h53, 8'h6D, 8'h75,
      8'h86, 8'h99, 8'hA7, 8'hBE, 8'hCA, 8'hDB, 8'hEF, 8'hFC };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;

   logic p_rdy, p_inv, p_rs, p_cs;  logic [HW-1:0] p_bus;
   logic b_rdy, b_inv, b_rs, b_cs;  logic [HW-1:0] b_bus;
   logic i_rdy, i_inv, i_rs, i_cs;  logic [HW-1:0] i_bus;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [HW-1:0] last_p = '0, last_b = '0, model_w = '0;
   int tg_p = 0, tg_b = 0;
   bit counting = 0;

   always #(CLK_P/2) clk = ~clk;

   pae_dram_addr_enc #(.HALF_W(HW), .MAP_PERM(1), .INV_EN(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(p_rdy), .bus_addr(p_bus), .bus_inv(p_inv),
      .row_strobe(p_rs), .col_strobe(p_cs));
   pae_dram_addr_enc #(.HALF_W(HW), .MAP_PERM(0), .INV_EN(0)) dut_bin_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(b_rdy), .bus_addr(b_bus), .bus_inv(b_inv),
      .row_strobe(b_rs), .col_strobe(b_cs));
   pae_dram_addr_enc #(.HALF_W(HW), .MAP_PERM(1), .INV_EN(1)) dut_inv_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(i_rdy), .bus_addr(i_bus), .bus_inv(i_inv),
      .row_strobe(i_rs), .col_strobe(i_cs));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      end
   endtask

   // Check one phase of address a on all three instances (sampled at negedge).
   task automatic phase_check(input bit is_row, input int a);
      logic [3:0] code;
      logic [HW-1:0] pexp, bexp, raw, wexp;
      bit iexp;
      code = VEC[a][3:0];
      pexp = is_row ? code[3:2] : code[1:0];
      bexp = is_row ? 2'(a >> 2) : 2'(a);
      check(p_rs == is_row && p_cs == !is_row, "R2 strobes", {p_rs, p_cs}, {is_row, !is_row});
      check(p_rdy == !is_row, "R3/R4 ready", p_rdy, !is_row);
      check(p_bus == pexp, is_row ? "R6 row half" : "R6 col half", p_bus, pexp);
      check(b_bus == bexp, "R9 binary half", b_bus, bexp);
      check(p_inv == 1'b0 && b_inv == 1'b0, "R11 invert off", p_inv | b_inv, 0);
      raw  = pexp;
      iexp = ($countones(raw ^ model_w) * 2 > HW);
      wexp = iexp ? ~raw : raw;
      check(i_bus == wexp && i_inv == iexp, "R10 invert stage", {i_inv, i_bus}, {iexp, wexp});
      check((i_bus ^ {HW{i_inv}}) == raw, "R12 restore", i_bus ^ {HW{i_inv}}, raw);
      model_w = wexp;
      if (counting) begin
         tg_p += $countones(p_bus ^ last_p);
         tg_b += $countones(b_bus ^ last_b);
      end
      last_p = p_bus;
      last_b = b_bus;
   endtask

   initial begin
      #(CLK_P * 2000);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(!p_rs && !p_cs && p_rdy && p_bus == 0 && !p_inv, "R1 reset held", {p_rs, p_cs, p_rdy}, 3'b001);
      rst_n = 1'b1;
      @(negedge clk);
      check(!i_rs && !i_cs && i_rdy && i_bus == 0 && !i_inv, "R1 after release", {i_rs, i_cs, i_rdy}, 3'b001);

      // R7: bijection of the expected permuted codes
      begin
         bit [15:0] seen = '0;
         for (int k = 0; k < 16; k++) seen[VEC[k][3:0]] = 1'b1;
         check(seen == 16'hFFFF, "R7 bijection", seen, 16'hFFFF);
      end

      // Sequential back-to-back sweep (R2, R4, R6, R8, R9, R10, R11, R12)
      counting = 1;
      for (int k = 0; k < 16; k++) begin
         req_valid = 1'b1;
         req_addr  = VEC[k][7:4];
         @(negedge clk);
         phase_check(1, k);
         req_valid = 1'b0;
         @(negedge clk);
         phase_check(0, k);
      end
      counting = 0;
      check(tg_p == 16, "R8 permuted transitions", tg_p, 16);
      check(tg_b == 30, "R8 binary transitions", tg_b, 30);
      check(tg_p < tg_b, "R8 permuted below binary", tg_p, tg_b);

      // R5: idle holds bus
      @(negedge clk);
      check(!p_rs && !p_cs && p_rdy, "R5 idle strobes", {p_rs, p_cs}, 0);
      check(p_bus == last_p && i_bus == model_w, "R5 idle bus hold", p_bus, last_p);

      // R3: request during the row cycle is ignored
      req_valid = 1'b1;
      req_addr  = 4'd5;
      @(negedge clk);
      phase_check(1, 5);
      req_addr  = 4'd9;
      @(negedge clk);
      phase_check(0, 5);
      req_valid = 1'b0;
      @(negedge clk);
      check(!p_rs && !p_cs && !i_rs, "R3 ignored request not issued", {p_rs, p_cs}, 0);
      check(p_bus == VEC[5][1:0], "R3 column from accepted address", p_bus, VEC[5][1:0]);
      @(negedge clk);
      check(p_bus == VEC[5][1:0] && i_bus == model_w, "R5 idle hold second cycle", p_bus, VEC[5][1:0]);

      summary();
      $finish;
   end

endmodule